// File: doc/BRIEF.md
# DMA Command Slot Queue

This block sits between a register front end and a copy engine. Software loads copy descriptors one at a time. The block parks each accepted descriptor in one of a fixed number of internal slots and starts no transfer. Each descriptor names one of two groups. A descriptor written with its launch flag set closes its group, and from then on the buffered operations of that group go out to the engine.

Descriptors leave in the order they were written, one at a time, over a valid/ready handshake. The engine answers each descriptor with a done pulse, and that pulse returns the descriptor's slot to the pool. When the last operation of a launched group is done, the group's interrupt rises, provided the closing descriptor asked for one. The interrupt stays high until software clears it by writing one.

A write is refused when no slot is free or when its group is still executing. Since a write must name some group, every write is refused while both groups are executing. A refused write leaves a sticky error flag.

Top module: `cmdq_slot_queue`

## Requirements
- R1: The queue has 20 slots. After reset `free_slots` reads 20. Each accepted write lowers it by one, and each `eng_done` for the descriptor in flight raises it by one. An accept and a done in the same cycle leave it unchanged.
- R2: An accepted descriptor is not offered to the engine (`eng_valid` stays 0) while its group has not been launched.
- R3: An accepted write with `wr_launch`=1 closes group `wr_grp`. All of that group's descriptors are then offered on `eng_data` in write order. While `eng_valid`=1 and `eng_ready`=0, `eng_valid` and `eng_data` hold.
- R4: Only one descriptor is in flight at a time. After the `eng_valid`/`eng_ready` handshake, `eng_valid` stays 0 until `eng_done` is seen for that descriptor.
- R5: `irq[g]` rises on the clock edge that takes the `eng_done` of the last outstanding operation of launched group g, and only if the closing descriptor had `wr_irq`=1. A `wr_irq` flag on a descriptor that does not close its group has no effect.
- R6: A group is busy from its launch until its last operation is done. A write naming a busy group is refused, so while both groups are busy every write is refused, even with free slots.
- R7: A write arriving while `free_slots` is 0 is dropped and is never dispatched.
- R8: Any refused write sets `err`, which stays 1 until reset. A refused write does not change `free_slots`.
- R9: `irq[g]` is a level that stays high until a cycle with `irq_clr[g]`=1. If a completion and a clear of the same group fall in one cycle, `irq[g]` stays high.
- R10: Slots drain strictly in write order across groups. The descriptors of a launched group wait behind older descriptors of a group that has not been launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_data | input | DATA_W | Descriptor payload |
| wr_irq | input | 1 | Interrupt request flag of this operation |
| wr_launch | input | 1 | Closes and launches the named group |
| wr_grp | input | GRP_W | Group selector (0 or 1) |
| irq_clr | input | NUM_GRP | Write-one-to-clear for the interrupts |
| eng_ready | input | 1 | Engine accepts the offered descriptor |
| eng_done | input | 1 | Engine finished the descriptor in flight |
| free_slots | output | CNT_W | Number of free slots |
| err | output | 1 | Sticky refused-write flag |
| eng_valid | output | 1 | Descriptor offered to the engine |
| eng_data | output | DATA_W | Offered descriptor payload |
| irq | output | NUM_GRP | Per-group completion interrupt |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a slot freed by `eng_done` and a new descriptor taking a slot. The second is a group completing and software clearing that group's interrupt. The bench drives the engine by hand in one test so that the done pulse, a fresh write and an `irq_clr` land on the same edge. It then expects `free_slots` to be unchanged and the interrupt to be set. A scoreboard holds the accepted descriptors in write order. Its engine model compares every offered descriptor against that queue, so refused writes and reordering across groups show up as mismatches or as leftover entries.

// File: rtl/cmdq_pkg.sv
`timescale 1ns/1ps
// Package shared by the command slot queue.
// Holds the per-group life-cycle encoding used by the group trackers.
package cmdq_pkg;
    // Group life cycle: empty, collecting descriptors, launched and executing
    typedef enum logic [1:0] {
        GRP_IDLE = 2'd0,
        GRP_OPEN = 2'd1,
        GRP_RUN  = 2'd2
    } grp_state_e;
endpackage

// File: rtl/cmdq_slot_ring.sv
`timescale 1ns/1ps
// Circular slot store for buffered descriptors.
// Assumes the caller never pushes when full and never pops when empty.
// The head entry stays visible until it is popped.
module cmdq_slot_ring #(
    parameter int DEPTH = 20,
    parameter int W     = 33,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head_data,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write; contents need no reset
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head_data = mem[rd_ptr];

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CNT_W'(DEPTH)));
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/cmdq_grp_track.sv
`timescale 1ns/1ps
// Tracks one group: the number of outstanding operations, launch state,
// the armed interrupt request and the interrupt level.
// Assumes no add arrives while the group is running and no sub before launch.
module cmdq_grp_track #(
    parameter int CNT_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add,
    input  logic close,
    input  logic want_irq,
    input  logic sub,
    input  logic clr,
    output logic busy,
    output logic irq_o
);
    import cmdq_pkg::*;

    grp_state_e       state;
    logic [CNT_W-1:0] pend;
    logic             armed;
    logic             finish;

    // Last outstanding operation of a launched group retires this cycle
    assign finish = (state == GRP_RUN) && sub && (pend == CNT_W'(1));

    // Outstanding count and life-cycle state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= GRP_IDLE;
            pend  <= '0;
            armed <= 1'b0;
        end else begin
            pend <= pend + CNT_W'(add) - CNT_W'(sub);
            case (state)
                GRP_IDLE, GRP_OPEN: if (add) begin
                    state <= close ? GRP_RUN : GRP_OPEN;
                    if (close) armed <= want_irq;
                end
                GRP_RUN: if (finish) state <= GRP_IDLE;
                default: state <= GRP_IDLE;
            endcase
        end
    end

    // Interrupt level: completion sets it and wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)              irq_o <= 1'b0;
        else if (finish && armed) irq_o <= 1'b1;
        else if (clr)            irq_o <= 1'b0;
    end

    assign busy = (state == GRP_RUN);

    assert_busy_has_work_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pend != '0));
    assert_irq_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (!busy && $past(sub)));
endmodule

// File: rtl/cmdq_slot_queue.sv
`timescale 1ns/1ps
// Command slot queue: buffers copy descriptors in slots and releases a group
// to the engine once it is launched. Raises a per-group interrupt when that
// group has fully completed. One descriptor is in flight at a time.
// Slots drain strictly in write order across groups.
module cmdq_slot_queue #(
    parameter  int SLOTS   = 20,
    parameter  int DATA_W  = 32,
    parameter  int NUM_GRP = 2,
    localparam int GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
    localparam int CNT_W   = $clog2(SLOTS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               wr_irq,
    input  logic               wr_launch,
    input  logic [GRP_W-1:0]   wr_grp,
    input  logic [NUM_GRP-1:0] irq_clr,
    input  logic               eng_ready,
    input  logic               eng_done,
    output logic [CNT_W-1:0]   free_slots,
    output logic               err,
    output logic               eng_valid,
    output logic [DATA_W-1:0]  eng_data,
    output logic [NUM_GRP-1:0] irq
);
    localparam int ENT_W = GRP_W + DATA_W;

    logic [CNT_W-1:0]   used;
    logic [ENT_W-1:0]   head;
    logic [GRP_W-1:0]   head_grp;
    logic [NUM_GRP-1:0] grp_busy;
    logic               accept, in_flight, fire, retire;

    // Intake: needs a free slot and a group that is not executing
    assign free_slots = CNT_W'(SLOTS) - used;
    assign accept     = wr_en && (used != CNT_W'(SLOTS)) && !grp_busy[wr_grp];

    // Dispatch: head entry of a launched group, nothing in flight
    assign head_grp  = head[ENT_W-1 -: GRP_W];
    assign eng_data  = head[DATA_W-1:0];
    assign eng_valid = (used != '0) && !in_flight && grp_busy[head_grp];
    assign fire      = eng_valid && eng_ready;
    assign retire    = in_flight && eng_done;

    cmdq_slot_ring #(.DEPTH(SLOTS), .W(ENT_W), .CNT_W(CNT_W)) i_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_data ({wr_grp, wr_data}),
        .pop       (retire),
        .head_data (head),
        .count     (used)
    );

    // One tracker per group
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        cmdq_grp_track #(.CNT_W(CNT_W)) i_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .add      (accept && (wr_grp == GRP_W'(g))),
            .close    (wr_launch),
            .want_irq (wr_irq),
            .sub      (retire && (head_grp == GRP_W'(g))),
            .clr      (irq_clr[g]),
            .busy     (grp_busy[g]),
            .irq_o    (irq[g])
        );
    end

    // In-flight flag: set by handshake, cleared by done
    always_ff @(posedge clk) begin
        if (!rst_n)      in_flight <= 1'b0;
        else if (fire)   in_flight <= 1'b1;
        else if (retire) in_flight <= 1'b0;
    end

    // Sticky error on any refused write
    always_ff @(posedge clk) begin
        if (!rst_n)                 err <= 1'b0;
        else if (wr_en && !accept)  err <= 1'b1;
    end

    assert_hold_offer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && !eng_ready) |=> (eng_valid && $stable(eng_data)));
    assert_single_flight_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !eng_valid);
    assert_both_busy_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (&grp_busy)) |=> (free_slots >= $past(free_slots)));
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    assert_free_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        free_slots <= CNT_W'(SLOTS));
endmodule

// File: tb/test_cmdq_slot_queue.sv
`timescale 1ns/1ps
// Scoreboard bench: writes push expected payloads, an engine model pops
// and compares each offered descriptor.
module test_cmdq_slot_queue;
    localparam int DW = 32;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          wr_en = 0, wr_irq = 0, wr_launch = 0;
    logic [DW-1:0] wr_data = '0;
    logic [0:0]    wr_grp = '0;
    logic [1:0]    irq_clr = '0;
    logic          eng_ready = 0, eng_done = 0;
    logic [4:0]    free_slots;
    logic          err, eng_valid;
    logic [DW-1:0] eng_data;
    logic [1:0]    irq;

    int            total = 0, bad = 0;
    logic [DW-1:0] exp_q[$];
    bit            eng_en = 0;
    bit            finished = 0;

    always #2.5 clk = ~clk;

    cmdq_slot_queue i_cmdq_slot_queue (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_irq(wr_irq), .wr_launch(wr_launch), .wr_grp(wr_grp),
        .irq_clr(irq_clr), .eng_ready(eng_ready), .eng_done(eng_done),
        .free_slots(free_slots), .err(err), .eng_valid(eng_valid),
        .eng_data(eng_data), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; wr_en = 0; irq_clr = '0; eng_en = 0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // Driver: one write; expected payload queued before the accepting edge
    task automatic wr(input logic [DW-1:0] d, input bit g, input bit fi,
                      input bit ln, input bit acc);
        @(negedge clk);
        wr_en = 1; wr_data = d; wr_grp = g; wr_irq = fi; wr_launch = ln;
        if (acc) exp_q.push_back(d);
        @(negedge clk);
        wr_en = 0; wr_irq = 0; wr_launch = 0;
    endtask

    task automatic wait_irq(input int g, input int lim, output bit got);
        got = 0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (irq[g]) begin got = 1; break; end
        end
    endtask

    // Monitor / engine model
    initial begin
        forever begin
            @(negedge clk);
            if (eng_en && eng_valid) begin
                if (exp_q.size() == 0)
                    check(0, "R3", "unexpected dispatch", eng_data, 0);
                else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    check(eng_data == e, "R3", "dispatch order", eng_data, e);
                end
                eng_ready = 1;
                @(negedge clk);
                eng_ready = 0;
                check(!eng_valid, "R4", "no offer while in flight", eng_valid, 0);
                repeat (2) @(negedge clk);
                eng_done = 1;
                @(negedge clk);
                eng_done = 0;
            end
        end
    end

    initial begin
        #100us;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit got;
        logic [DW-1:0] d0;
        do_reset();
        check(free_slots == 20, "R1", "reset free", free_slots, 20);
        check(!eng_valid && irq == 0 && !err, "R1", "reset outputs",
              {eng_valid, irq, err}, 0);

        // R2 buffered without launch, then launch with irq
        eng_en = 1;
        wr('h100, 0, 0, 0, 1); wr('h101, 0, 0, 0, 1); wr('h102, 0, 0, 0, 1);
        repeat (6) @(negedge clk);
        check(!eng_valid && exp_q.size() == 3, "R2", "held before launch",
              exp_q.size(), 3);
        check(free_slots == 17, "R1", "free after 3", free_slots, 17);
        wr('h103, 0, 1, 1, 1);
        wait_irq(0, 300, got);
        check(got, "R5", "irq0 after group", got, 1);
        check(exp_q.size() == 0, "R3", "group drained", exp_q.size(), 0);
        check(free_slots == 20, "R1", "slots returned", free_slots, 20);
        repeat (3) @(negedge clk);
        check(irq[0], "R9", "irq level held", irq[0], 1);
        @(negedge clk); irq_clr = 2'b01; @(negedge clk); irq_clr = 0;
        check(irq[0] == 0, "R9", "irq cleared", irq[0], 0);

        // R5 flag on a non-final op ignored, final op unflagged
        wr('h200, 1, 1, 0, 1); wr('h201, 1, 0, 1, 1);
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R3", "group1 drained", exp_q.size(), 0);
        check(irq[1] == 0, "R5", "no irq without final flag", irq[1], 0);

        // R6 / R8 busy refusal
        do_reset();
        wr('h300, 0, 1, 1, 1);
        check(!err, "R8", "err clear before refusal", err, 0);
        wr('h301, 0, 0, 0, 0);
        check(err, "R8", "err set on refusal", err, 1);
        check(free_slots == 19, "R6", "busy group refused", free_slots, 19);
        wr('h302, 1, 1, 1, 1);
        wr('h303, 1, 0, 0, 0);
        check(free_slots == 18, "R6", "both busy refused", free_slots, 18);
        d0 = eng_data;
        repeat (3) @(negedge clk);
        check(eng_valid && eng_data == d0, "R3", "offer held", eng_data, d0);
        eng_en = 1;
        wait_irq(1, 300, got);
        check(irq == 2'b11, "R5", "both irqs", irq, 3);
        check(exp_q.size() == 0 && err, "R8", "drained, err sticky",
              exp_q.size(), 0);

        // R7 full queue drop
        do_reset();
        for (int i = 0; i < 19; i++) wr('h400 + i, 0, 0, 0, 1);
        wr('h500, 0, 1, 1, 1);
        check(free_slots == 0, "R1", "queue full", free_slots, 0);
        wr('h600, 1, 0, 0, 0);
        check(err && free_slots == 0, "R7", "drop when full", {err, free_slots}, 'h20);
        eng_en = 1;
        wait_irq(0, 2000, got);
        repeat (20) @(negedge clk);
        check(got && exp_q.size() == 0, "R7", "dropped never sent", exp_q.size(), 0);
        check(free_slots == 20, "R1", "all freed", free_slots, 20);

        // R10 order across groups
        do_reset();
        eng_en = 1;
        wr('h700, 0, 0, 0, 1); wr('h701, 1, 1, 1, 1);
        repeat (8) @(negedge clk);
        check(!eng_valid && exp_q.size() == 2, "R10", "waits behind older",
              exp_q.size(), 2);
        wr('h702, 0, 1, 1, 1);
        wait_irq(0, 300, got);
        check(irq == 2'b11 && exp_q.size() == 0, "R10", "order kept", irq, 3);

        // Same cycle: done + accept + clear
        do_reset();
        wr('h800, 0, 1, 1, 0);
        check(eng_valid && eng_data == 'h800, "R3", "manual offer", eng_data, 'h800);
        eng_ready = 1; @(negedge clk); eng_ready = 0;
        check(free_slots == 19, "R1", "one in flight", free_slots, 19);
        eng_done = 1; wr_en = 1; wr_data = 'h801; wr_grp = 1; wr_irq = 0;
        wr_launch = 0; irq_clr = 2'b01; exp_q.push_back('h801);
        @(negedge clk);
        eng_done = 0; wr_en = 0; irq_clr = 0;
        check(free_slots == 19, "R1", "accept and done same cycle", free_slots, 19);
        check(irq[0], "R9", "set wins over clear", irq[0], 1);
        eng_en = 1;
        wr('h802, 1, 1, 1, 1);
        wait_irq(1, 300, got);
        check(got && exp_q.size() == 0, "R5", "group1 irq", exp_q.size(), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule